// File: doc/BRIEF.md
# Fuse Array Access Controller

This block is a register-mapped controller for a one-time-programmable fuse array. It holds a behavioural model of the array: a word-addressed store in which a bit can go from 0 to 1 but never back. Software reaches the block over a plain synchronous register port. It writes a control word and, for programming, a data word. It then writes 1 to the enable register, polls the status register for a completion flag, and clears that flag by writing 1 to its bit. Read results appear in a window of consecutive data-out registers.

A read operation copies a burst of 1 to `MAX_BURST` consecutive words into the window. A program operation burns the bits requested in the program-data register into one word. It then reads the word back and raises either write-done or verify-fail. Cells listed by the `DEFECT_IDX`/`DEFECT_MASK` parameters never burn, so the verify path can be reached. Operations that are out of range or malformed raise the error flag without touching the array. Every valid operation keeps the block busy for `BUSY_CYC` cycles plus its transfer cycles.

Register reads are combinational on `reg_addr`. A write takes effect at the clock edge where `reg_wr` is high. Because the block has no data stream, there is no back-pressure. Software must not start a new operation until a completion flag appears.

Top module: `fuse_ctrl`

## Requirements
- R1: Register byte offsets: control 0x04, enable 0x08, program data 0x10, data-out word i at 0x20+4*i, status 0x84. Control and program data read back what was written, enable and unmapped offsets read 0, and status reads its flags at bits 1..4 with the other bits 0.
- R2: The control word holds the word index in bits 31:16, the burst count in bits 15:8 and the command in bits 7:0. Command 0 is read and command 2 is program.
- R3: A read with count 1..8 copies words index..index+count-1 into data-out entries 0..count-1 and then sets read-done (status bit 1).
- R4: When index+count exceeds 768 for a read, or the index exceeds 767 for a program, the block sets error (bit 4) only. The array and the data-out window stay unchanged, and a read ending exactly at word 767 is accepted.
- R5: A read with count 0 or count above 8, or any command other than 0 and 2, sets error (bit 4) on the enable edge itself and starts no operation.
- R6: A program ORs the program-data bits into the addressed word, so bits only go from 0 to 1. The count field is ignored for a program, and write-done (bit 3) is set when the read-back holds every requested bit.
- R7: When a requested bit sits in a defective cell (word `DEFECT_IDX`, bits `DEFECT_MASK`, by default word 766 bit 8), the block sets verify-fail (bit 2) instead of write-done. The other requested bits are still burned.
- R8: Writing 1 to a status bit clears that bit, and writing 0 leaves it unchanged. Writing back the value read clears every pending flag, and at most one flag event happens per cycle.
- R9: Writing 0 to enable starts nothing, and an enable write that arrives while an operation is running is ignored.
- R10: After reset the array, the status flags, the control and program-data registers and the data-out window are all zero.
- R11: No completion flag appears within `BUSY_CYC` cycles of the enable edge of a valid operation.
- R12: The data-out window keeps the last successful burst through program operations and errors, until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |

## Verification
Directed cases cover the edges of the parameter space. These are bursts at index 0 and at the last legal window, one word past the end, counts 0 and 9, unknown commands, and the defective cell. Each separates the error, verify-fail and done paths. Repeated programs of one word with overlapping masks tell an OR merge apart from an overwrite. A program with a nonzero count field shows that its neighbours stay untouched. A seeded random mix of reads, programs and malformed commands over a small index range makes programs and bursts overlap. This exposes off-by-one burst addressing and stale data-out entries against a bench model of the array.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h04;
  localparam logic [7:0] OFS_EN    = 8'h08;
  localparam logic [7:0] OFS_PDATA = 8'h10;
  localparam logic [7:0] OFS_DOUT  = 8'h20;
  localparam logic [7:0] OFS_STAT  = 8'h84;

  localparam logic [7:0] OP_READ = 8'd0;
  localparam logic [7:0] OP_PROG = 8'd2;

  // status flag positions, software-visible
  localparam int ST_RD  = 1;
  localparam int ST_VF  = 2;
  localparam int ST_WR  = 3;
  localparam int ST_ERR = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_XFER, S_PROG, S_CHECK
  } seq_state_t;
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int          WORDS       = 768,
  parameter int          WIDTH       = 32,
  parameter int          AW          = 10,
  parameter int          DEFECT_IDX  = 766,
  parameter logic [31:0] DEFECT_MASK = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata
);
  logic [WIDTH-1:0] mem_q [WORDS];
  logic [WIDTH-1:0] dead;

  generate
    if (DEFECT_MASK != 32'h0) begin : g_defect
      assign dead = (int'(waddr) == DEFECT_IDX) ? DEFECT_MASK[WIDTH-1:0] : '0;
    end else begin : g_clean
      assign dead = '0;
    end
  endgenerate

  assign rdata = (int'(raddr) < WORDS) ? mem_q[raddr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we && int'(waddr) < WORDS) begin
      mem_q[waddr] <= mem_q[waddr] | (wdata & ~dead);
    end
  end

  // R6: a burn never clears a bit that was already set
  p_only_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we && int'(waddr) < WORDS |=>
      (mem_q[$past(waddr)] & $past(mem_q[waddr])) == $past(mem_q[waddr]));
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int WORDS     = 768,
  parameter int WIDTH     = 32,
  parameter int AW        = 10,
  parameter int MAX_BURST = 8,
  parameter int BUSY_CYC  = 4,
  localparam int KW = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1,
  localparam int BW = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      ctrl_word,
  input  logic [WIDTH-1:0] pdata,
  output logic [AW-1:0]    mem_addr,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic             mem_we,
  output logic [WIDTH-1:0] mem_wdata,
  output logic             dout_we,
  output logic [KW-1:0]    dout_sel,
  output logic             ev_rd,
  output logic             ev_wr,
  output logic             ev_vf,
  output logic             ev_err
);
  seq_state_t       st_q;
  logic [AW-1:0]    idx_q;
  logic [KW:0]      cnt_q;
  logic [KW-1:0]    k_q;
  logic [BW-1:0]    bc_q;
  logic [WIDTH-1:0] pd_q;
  logic             is_rd_q;

  logic [7:0]  cmd_f, cnt_f;
  logic [15:0] idx_f;
  logic [16:0] end_f;
  logic        bad, accept, last;

  assign cmd_f = ctrl_word[7:0];
  assign cnt_f = ctrl_word[15:8];
  assign idx_f = ctrl_word[31:16];
  assign end_f = {1'b0, idx_f} + ((cmd_f == OP_READ) ? {9'd0, cnt_f} : 17'd1);

  always_comb begin
    bad = 1'b1;
    if (cmd_f == OP_READ)
      bad = (cnt_f == 8'd0) || (int'(cnt_f) > MAX_BURST) || (int'(end_f) > WORDS);
    else if (cmd_f == OP_PROG)
      bad = int'(end_f) > WORDS;
  end

  assign accept = start && (st_q == S_IDLE);
  assign last   = ({1'b0, k_q} == cnt_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      k_q     <= '0;
      bc_q    <= '0;
      pd_q    <= '0;
      is_rd_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept && !bad) begin
          idx_q   <= idx_f[AW-1:0];
          cnt_q   <= cnt_f[KW:0];
          pd_q    <= pdata;
          is_rd_q <= (cmd_f == OP_READ);
          bc_q    <= '0;
          k_q     <= '0;
          st_q    <= S_WAIT;
        end
        S_WAIT: begin
          if (int'(bc_q) == BUSY_CYC - 1) st_q <= is_rd_q ? S_XFER : S_PROG;
          else bc_q <= bc_q + 1'b1;
        end
        S_XFER: begin
          k_q <= k_q + 1'b1;
          if (last) begin
            k_q  <= '0;
            st_q <= S_IDLE;
          end
        end
        S_PROG:  st_q <= S_CHECK;
        S_CHECK: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr  = idx_q + AW'(k_q);
    mem_we    = (st_q == S_PROG);
    mem_wdata = pd_q;
    dout_we   = (st_q == S_XFER);
    dout_sel  = k_q;
    ev_rd     = (st_q == S_XFER) && last;
    ev_wr     = (st_q == S_CHECK) && ((mem_rdata & pd_q) == pd_q);
    ev_vf     = (st_q == S_CHECK) && ((mem_rdata & pd_q) != pd_q);
    ev_err    = accept && bad;
  end

  // R9: operation parameters hold while busy, so a late enable is ignored
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != S_IDLE |=> $stable(idx_q) && $stable(pd_q));
  // R5: an unknown command never leaves idle
  p_unknown_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && st_q == S_IDLE && cmd_f != OP_READ && cmd_f != OP_PROG |=> st_q == S_IDLE);
  // R4: every array access stays inside the array
  p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_we || mem_we) |-> int'(mem_addr) < WORDS);
  // R11: no completion in the first BUSY_CYC cycles
  p_wait_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_WAIT && int'(bc_q) < BUSY_CYC - 1 |=> st_q == S_WAIT);
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int          WORDS       = 768,
  parameter int          MAX_BURST   = 8,
  parameter int          BUSY_CYC    = 4,
  parameter int          DEFECT_IDX  = 766,
  parameter logic [31:0] DEFECT_MASK = 32'h0000_0100,
  localparam int WIDTH = 32,
  localparam int AW    = $clog2(WORDS),
  localparam int KW    = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  logic [31:0]      ctrl_q, pdata_q;
  logic [4:1]       stat_q, clr, evs;
  logic [WIDTH-1:0] dout_q [MAX_BURST];

  logic             start, mem_we, dout_we;
  logic             ev_rd, ev_wr, ev_vf, ev_err;
  logic [AW-1:0]    mem_addr;
  logic [WIDTH-1:0] mem_rdata, mem_wdata;
  logic [KW-1:0]    dout_sel;
  logic [7:0]       win_ofs;

  assign start = reg_wr && reg_addr == OFS_EN && reg_wdata[0];
  assign clr   = (reg_wr && reg_addr == OFS_STAT) ? reg_wdata[4:1] : 4'b0;
  assign evs   = {ev_err, ev_wr, ev_vf, ev_rd};

  fuse_array #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW),
               .DEFECT_IDX(DEFECT_IDX), .DEFECT_MASK(DEFECT_MASK)) u_array (
    .clk(clk), .rst_n(rst_n), .raddr(mem_addr), .rdata(mem_rdata),
    .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata));

  fuse_seq #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW),
             .MAX_BURST(MAX_BURST), .BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_q), .pdata(pdata_q),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .dout_we(dout_we), .dout_sel(dout_sel),
    .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_vf(ev_vf), .ev_err(ev_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pdata_q <= '0;
      stat_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_CTRL)  ctrl_q  <= reg_wdata;
      if (reg_wr && reg_addr == OFS_PDATA) pdata_q <= reg_wdata;
      stat_q <= (stat_q & ~clr) | evs;   // a new event wins over a same-cycle clear
    end
  end

  generate
    for (genvar g = 0; g < MAX_BURST; g++) begin : g_dout
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_q[g] <= '0;
        else if (dout_we && int'(dout_sel) == g) dout_q[g] <= mem_rdata;
      end
    end
  endgenerate

  assign win_ofs = reg_addr - OFS_DOUT;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL)       reg_rdata = ctrl_q;
    else if (reg_addr == OFS_PDATA) reg_rdata = pdata_q;
    else if (reg_addr == OFS_STAT)  reg_rdata = {27'd0, stat_q, 1'b0};
    else if (reg_addr >= OFS_DOUT && int'(win_ofs) < 4 * MAX_BURST && win_ofs[1:0] == 2'b00)
      reg_rdata = dout_q[win_ofs[KW+1:2]];
  end

  // R8: writing 1 clears a flag unless the same flag fires in that cycle
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == OFS_STAT && reg_wdata[ST_RD] && !ev_rd |=> !stat_q[ST_RD]);
  // R8: one completion event at a time
  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rd, ev_wr, ev_vf, ev_err}));
  // R5: an error event is visible after the edge
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> stat_q[ST_ERR]);
endmodule

// File: tb/sim_fuse_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_ctrl;
  localparam int BUSY  = 4;
  localparam int DIDX  = 766;
  localparam logic [31:0] DMASK = 32'h0000_0100;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;
  logic [31:0] model [768];
  logic [31:0] last_dout [8];

  always #4 clk = ~clk;  // 125 MHz

  fuse_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] cw(input int idx, input int cnt, input int cmd);
    return {idx[15:0], cnt[7:0], cmd[7:0]};
  endfunction

  function automatic logic [31:0] exp_stat(input int idx, input int cnt, input int cmd,
                                           input logic [31:0] pd);
    logic [31:0] burn;
    if (cmd == 0) return (cnt == 0 || cnt > 8 || idx + cnt > 768) ? 32'h10 : 32'h02;
    if (cmd != 2) return 32'h10;
    if (idx >= 768) return 32'h10;
    burn = (idx == DIDX) ? (pd & ~DMASK) : pd;
    return (((model[idx] | burn) & pd) == pd) ? 32'h08 : 32'h04;
  endfunction

  // run one operation, check flag, model and window; clear flags afterwards
  task automatic run_op(input string tag, input int idx, input int cnt, input int cmd,
                        input logic [31:0] pd);
    logic [31:0] st, v, e;
    e = exp_stat(idx, cnt, cmd, pd);
    wr(8'h10, pd);
    wr(8'h04, cw(idx, cnt, cmd));
    wr(8'h08, 32'h1);
    st = 0;
    for (int t = 0; t < 100 && st == 0; t++) begin
      rd(8'h84, st);
      if (st == 0) @(negedge clk);
    end
    chk({tag, " status"}, st, e);
    if (e == 32'h08 || e == 32'h04)
      model[idx] = model[idx] | ((idx == DIDX) ? (pd & ~DMASK) : pd);
    if (e == 32'h02)
      for (int i = 0; i < cnt; i++) last_dout[i] = model[idx + i];
    for (int i = 0; i < 8; i++) begin
      rd(8'h20 + 8'(4 * i), v);
      chk({tag, " window R12 R3"}, v, last_dout[i]);
    end
    wr(8'h84, st);
    rd(8'h84, v);
    chk({tag, " cleared R8"}, v, 32'h0);
  endtask

  task automatic read_word(input int idx, output logic [31:0] d);
    wr(8'h04, cw(idx, 1, 0)); wr(8'h08, 1);
    repeat (BUSY + 4) @(negedge clk);
    rd(8'h20, d);
    for (int i = 0; i < 1; i++) last_dout[i] = model[idx];
    wr(8'h84, 32'h1e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 768; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) last_dout[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 / R1 reset state and map
    rd(8'h84, v); chk("R10 status", v, 0);
    rd(8'h04, v); chk("R10 ctrl", v, 0);
    rd(8'h10, v); chk("R10 pdata", v, 0);
    for (int i = 0; i < 8; i++) begin rd(8'h20 + 8'(4 * i), v); chk("R10 dout", v, 0); end
    wr(8'h10, 32'hdead_beef); rd(8'h10, v); chk("R1 pdata readback", v, 32'hdead_beef);
    wr(8'h04, 32'h0003_0100); rd(8'h04, v); chk("R1 R2 ctrl readback", v, 32'h0003_0100);
    rd(8'h08, v); chk("R1 enable reads 0", v, 0);
    rd(8'h40, v); chk("R1 unmapped", v, 0);

    // R9: enable write of 0 starts nothing
    wr(8'h08, 32'h0); repeat (BUSY + 12) @(negedge clk);
    rd(8'h84, v); chk("R9 enable 0", v, 0);

    // R3 burst and R6 merge, count ignored on program
    run_op("R3 burst0", 0, 8, 0, 0);
    run_op("R6 prog a", 5, 7, 2, 32'h0000_00a5);
    run_op("R6 prog b", 5, 0, 2, 32'h0000_000f);
    run_op("R6 R3 neighbours", 4, 3, 0, 0);
    chk("R6 merged word", last_dout[1], 32'h0000_00af);

    // R7 defective cell
    run_op("R7 defect", DIDX, 1, 2, 32'h0000_0101);
    run_op("R7 readback", DIDX, 1, 0, 0);
    chk("R7 other bit burned", last_dout[0], 32'h0000_0001);
    run_op("R7 clean bit ok", DIDX, 1, 2, 32'h0000_0010);

    // R4 range boundaries
    run_op("R4 last window", 760, 8, 0, 0);
    run_op("R4 past end", 764, 5, 0, 0);
    run_op("R4 prog past end", 768, 1, 2, 32'hffff_ffff);
    run_op("R4 prog last", 767, 1, 2, 32'h8000_0000);

    // R5 malformed
    run_op("R5 count0", 3, 0, 0, 0);
    run_op("R5 count9", 3, 9, 0, 0);
    run_op("R5 cmd1", 3, 1, 1, 32'h1);
    run_op("R5 cmd3", 3, 1, 3, 32'h1);

    // R11 latency and R9 busy-ignore
    wr(8'h04, cw(5, 1, 0)); wr(8'h08, 1);
    rd(8'h84, v); chk("R11 early", v, 0);
    wr(8'h04, cw(6, 1, 0)); wr(8'h08, 1);
    rd(8'h84, v); chk("R11 during wait", v, 0);
    repeat (BUSY + 4) @(negedge clk);
    rd(8'h84, v); chk("R9 one flag", v, 32'h02);
    rd(8'h20, v); chk("R9 first op data", v, model[5]);
    last_dout[0] = model[5];
    wr(8'h84, v); repeat (BUSY + 12) @(negedge clk);
    rd(8'h84, v); chk("R9 no second op", v, 0);

    // R8 partial clear with two pending flags
    read_word(0, v);
    wr(8'h04, cw(0, 1, 0)); wr(8'h08, 1); repeat (BUSY + 4) @(negedge clk);
    wr(8'h04, cw(0, 1, 7)); wr(8'h08, 1);
    rd(8'h84, v); chk("R8 two flags", v, 32'h12);
    wr(8'h84, 32'h02); rd(8'h84, v); chk("R8 clear one", v, 32'h10);
    wr(8'h84, 32'h00); rd(8'h84, v); chk("R8 write 0 keeps", v, 32'h10);
    wr(8'h84, v); rd(8'h84, v); chk("R8 writeback clears", v, 0);

    // random mix
    for (int n = 0; n < 120; n++) begin
      int kind, idx, cnt, cmd;
      logic [31:0] pd;
      kind = int'($urandom % 5);
      idx = int'($urandom % 24);
      cnt = 1 + int'($urandom % 8);
      cmd = 0;
      pd  = $urandom & $urandom & $urandom;
      if (kind <= 1) cmd = 2;
      if (kind == 3) begin idx = 760 + int'($urandom % 10); end
      if (kind == 4) begin cnt = int'($urandom % 11); cmd = int'($urandom % 4); end
      if (n % 17 == 0) begin idx = DIDX; cmd = 2; end
      run_op("R3 R6 random", idx, cnt, cmd, pd);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule